// File: doc/BRIEF.md
# Keyed Watchdog with NMI Pre-Warning

This block is a watchdog timer that software controls through one write port carrying an enable bit and a 3-bit key. After it has started, software must service it before a first timeout runs out. Servicing means restarting it or stopping it. If that timeout expires, the block raises a non-maskable interrupt request. A handler that wakes on that request gets one more short grace period to service the watchdog. If the grace period also expires, the block pulses a chip reset output and goes back to the stopped state.

A write that restarts or stops the watchdog is accepted only when its key is the bitwise inverse of the stored key. Each accepted restart stores the new key, so software flips its own copy with an XOR of all ones before every service. A write with any other key only overwrites the stored key and leaves the timeout running. This means a runaway program that repeats one write cannot keep the watchdog alive.

The state machine has three states:
- `ST_STOPPED`: idle, which is the state after reset.
- `ST_ARMED`: the first timeout is counting.
- `ST_WARNING`: the NMI request is asserted and the grace period is counting.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | `ST_STOPPED` | `ST_ARMED` | enable=1 write |
| kick | `ST_ARMED` or `ST_WARNING` | `ST_ARMED` | valid enable=1 write |
| halt | `ST_ARMED` or `ST_WARNING` | `ST_STOPPED` | valid enable=0 write |
| warn | `ST_ARMED` | `ST_WARNING` | first timeout expires |
| bite | `ST_WARNING` | `ST_STOPPED` | grace period expires; pulses the reset output |

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is stopped: `active`, `nmi_req` and `chip_rst` are all 0.
- R2: While stopped, a write with enable=0 has no effect, whatever its key. The watchdog stays stopped and never raises `nmi_req`.
- R3: While stopped, a write with enable=1 starts the watchdog (`active`=1) and stores the written key, and the first timeout begins from that write.
- R4: While running, a write with enable=1 whose key equals the bitwise NOT of the stored key restarts the first timeout and stores the written key. The next valid write must therefore use that key inverted.
- R5: While running, a write with enable=0 whose key equals the bitwise NOT of the stored key stops the watchdog and clears `nmi_req`.
- R6: While running, a write whose key is not the inverse of the stored key replaces the stored key with the written value and does not restart either timeout.
- R7: `nmi_req` rises exactly WARN_CYCLES clock cycles after the write that started or last restarted the watchdog. It stays high until a valid write or the chip reset.
- R8: If no valid write arrives, `chip_rst` is a one-cycle pulse GRACE_CYCLES cycles after `nmi_req` rose. In the same cycle `nmi_req` and `active` drop to 0.
- R9: A valid restart while `nmi_req` is high clears it in the next cycle and starts a full first timeout again.
- R10: A valid write in the cycle in which either timeout would expire takes priority over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control port |
| wr_enable | input | 1 | Enable bit of the written word |
| wr_key | input | KEY_W | Key field of the written word |
| active | output | 1 | Watchdog is running (armed or warning) |
| nmi_req | output | 1 | Non-maskable interrupt request |
| chip_rst | output | 1 | One-cycle chip reset pulse |

## Verification
The bench builds the block with WARN_CYCLES=20 and GRACE_CYCLES=6 instead of the sub-second defaults. At those sizes the complete NMI-then-reset escalation takes a few dozen cycles. That lets the bench check each timeout edge at the exact cycle, on both sides. It also puts writes on the very cycle of expiry, so the priority rule can be tested. The key values are chosen so that stale keys, repeated keys and the expected inverse all occur, and the key that is stored is inferred from which later write gets accepted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WARNING = 2'd2
    } wdog_state_e;

endpackage

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int WARN_CYCLES  = 2_500_000,
    parameter int GRACE_CYCLES = 82_500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic in_grace,
    output logic expired
);
    localparam int LIMIT = (WARN_CYCLES > GRACE_CYCLES) ? WARN_CYCLES : GRACE_CYCLES;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] WARN_LAST  = CNT_W'(WARN_CYCLES - 1);
    localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        expired = run && (cnt_q == (in_grace ? GRACE_LAST : WARN_LAST));
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int KEY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             expired,
    output logic             cnt_clr,
    output logic             cnt_run,
    output logic             in_grace,
    output logic [KEY_W-1:0] key_q,
    output logic             active,
    output logic             nmi_req,
    output logic             chip_rst
);
    wdog_state_e state_q, state_d;
    logic [KEY_W-1:0] key_d;
    logic running, key_ok, kick, halt, bite;

    always_comb begin
        running = (state_q != ST_STOPPED);
        key_ok  = (wr_key == ~key_q);
        kick    = running && wr_en && wr_enable && key_ok;
        halt    = running && wr_en && !wr_enable && key_ok;
        bite    = 1'b0;
        state_d = state_q;
        key_d   = key_q;
        if (wr_en && (running || wr_enable)) begin
            key_d = wr_key;
        end
        unique case (state_q)
            ST_STOPPED: begin
                if (wr_en && wr_enable) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (halt)         state_d = ST_STOPPED;
                else if (kick)    state_d = ST_ARMED;
                else if (expired) state_d = ST_WARNING;
            end
            ST_WARNING: begin
                if (halt)      state_d = ST_STOPPED;
                else if (kick) state_d = ST_ARMED;
                else if (expired) begin
                    state_d = ST_STOPPED;
                    bite    = 1'b1;
                end
            end
            default: state_d = ST_STOPPED;
        endcase
        cnt_clr  = (state_d != state_q) || kick;
        cnt_run  = running;
        in_grace = (state_q == ST_WARNING);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            key_q   <= key_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_rst <= 1'b0;
        end else begin
            chip_rst <= bite;
        end
    end

    always_comb begin
        active  = running;
        nmi_req = (state_q == ST_WARNING);
    end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int KEY_W        = 3,
    parameter int WARN_CYCLES  = 2_500_000,
    parameter int GRACE_CYCLES = 82_500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [KEY_W-1:0] wr_key,
    output logic             active,
    output logic             nmi_req,
    output logic             chip_rst
);
    logic cnt_clr, cnt_run, in_grace, expired;
    logic [KEY_W-1:0] key_q;

    wdog_timer #(
        .WARN_CYCLES (WARN_CYCLES),
        .GRACE_CYCLES(GRACE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .run     (cnt_run),
        .in_grace(in_grace),
        .expired (expired)
    );

    wdog_ctrl #(
        .KEY_W(KEY_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_enable(wr_enable),
        .wr_key   (wr_key),
        .expired  (expired),
        .cnt_clr  (cnt_clr),
        .cnt_run  (cnt_run),
        .in_grace (in_grace),
        .key_q    (key_q),
        .active   (active),
        .nmi_req  (nmi_req),
        .chip_rst (chip_rst)
    );

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
    parameter int KEY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_enable,
    input logic [KEY_W-1:0] wr_key,
    input logic [KEY_W-1:0] key_q,
    input logic             active,
    input logic             nmi_req,
    input logic             chip_rst
);
    logic valid_wr;
    assign valid_wr = active && wr_en && (wr_key == ~key_q);

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(wr_en && wr_enable)) |=> !active); // R2

    AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && wr_en && wr_enable) |=> (active && key_q == $past(wr_key))); // R3

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_wr && wr_enable) |=> (active && !nmi_req && !chip_rst)); // R9

    AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_wr && !wr_enable) |=> (!active && !nmi_req)); // R5

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_en && !(wr_key == ~key_q)) |=> (key_q == $past(wr_key))); // R6

    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !valid_wr) |=> (nmi_req || chip_rst)); // R7

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> !chip_rst); // R8

    AST_RST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> (!active && !nmi_req)); // R8

    AST_NMI_IMPLIES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> active); // R7

endmodule

bind keyed_wdog keyed_wdog_chk #(.KEY_W(KEY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_enable(wr_enable),
    .wr_key   (wr_key),
    .key_q    (key_q),
    .active   (active),
    .nmi_req  (nmi_req),
    .chip_rst (chip_rst)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
    localparam int KW = 3;
    localparam int WC = 20;
    localparam int GC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_enable = 1'b0;
    logic [KW-1:0] wr_key = '0;
    logic active, nmi_req, chip_rst;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    keyed_wdog #(.KEY_W(KW), .WARN_CYCLES(WC), .GRACE_CYCLES(GC)) i_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_enable(wr_enable),
        .wr_key(wr_key), .active(active), .nmi_req(nmi_req), .chip_rst(chip_rst)
    );

    typedef struct packed {
        logic          do_wr;
        logic          en;
        logic [KW-1:0] key;
        logic [7:0]    dly;
        logic          exp_act;
        logic          exp_nmi;
        logic [3:0]    req;
    } step_t;

    localparam step_t TAB [10] = '{
        '{1'b1, 1'b0, 3'd5, 8'd30, 1'b0, 1'b0, 4'd2},  // R2 ignored write
        '{1'b1, 1'b1, 3'd2, 8'd19, 1'b1, 1'b0, 4'd3},  // R3 start, just before timeout
        '{1'b0, 1'b0, 3'd0, 8'd1,  1'b1, 1'b1, 4'd7},  // R7 nmi at WC
        '{1'b1, 1'b1, 3'd5, 8'd0,  1'b1, 1'b0, 4'd9},  // R9 kick clears nmi
        '{1'b1, 1'b1, 3'd3, 8'd0,  1'b1, 1'b0, 4'd6},  // R6 bad key stored
        '{1'b0, 1'b0, 3'd0, 8'd17, 1'b1, 1'b0, 4'd6},
        '{1'b0, 1'b0, 3'd0, 8'd2,  1'b1, 1'b1, 4'd6},  // R6 no restart
        '{1'b1, 1'b1, 3'd2, 8'd0,  1'b1, 1'b1, 4'd6},  // R6 stale inverse rejected
        '{1'b1, 1'b0, 3'd5, 8'd0,  1'b0, 1'b0, 4'd5},  // R5 valid stop
        '{1'b0, 1'b0, 3'd0, 8'd40, 1'b0, 1'b0, 4'd2}
    };

    task automatic chk(input string req, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, a, e);
        end
    endtask

    task automatic wr(input logic en, input logic [KW-1:0] k);
        wr_en = 1'b1; wr_enable = en; wr_key = k;
        @(negedge clk);
        wr_en = 1'b0; wr_enable = 1'b0; wr_key = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: bench hung");
        finish_run();
    end

    initial begin
        idle(2);
        chk("R1 active", active, 1'b0);
        chk("R1 nmi", nmi_req, 1'b0);
        chk("R1 chip_rst", chip_rst, 1'b0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 active after release", active, 1'b0);

        for (int s = 0; s < 10; s++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", TAB[s].req, s);
            if (TAB[s].do_wr) wr(TAB[s].en, TAB[s].key);
            idle(int'(TAB[s].dly));
            chk({tag, " active"}, active, TAB[s].exp_act);
            chk({tag, " nmi"}, nmi_req, TAB[s].exp_nmi);
        end

        // R8 full escalation to chip reset
        wr(1'b1, 3'd0);
        idle(WC + GC - 1);
        chk("R8 nmi before bite", nmi_req, 1'b1);
        chk("R8 no rst yet", chip_rst, 1'b0);
        idle(1);
        chk("R8 rst pulse", chip_rst, 1'b1);
        chk("R8 stopped", active, 1'b0);
        chk("R8 nmi dropped", nmi_req, 1'b0);
        idle(1);
        chk("R8 pulse one cycle", chip_rst, 1'b0);

        // R10 kick on the first-timeout edge, R4 timing and key flip
        wr(1'b1, 3'd1);
        idle(WC - 1);
        wr(1'b1, 3'd6);
        chk("R10 kick wins warn", nmi_req, 1'b0);
        idle(WC - 1);
        chk("R4 restart full window", nmi_req, 1'b0);
        idle(1);
        chk("R4 nmi after restart", nmi_req, 1'b1);
        wr(1'b1, 3'd1);
        chk("R4 flipped key accepted", nmi_req, 1'b0);
        wr(1'b0, 3'd6);
        chk("R4 second flip stops", active, 1'b0);

        // R10 kick on the grace edge
        wr(1'b1, 3'd4);
        idle(WC + GC - 1);
        wr(1'b1, 3'd3);
        chk("R10 kick wins bite active", active, 1'b1);
        chk("R10 kick wins bite rst", chip_rst, 1'b0);
        chk("R10 kick wins bite nmi", nmi_req, 1'b0);

        // R1 reset while running
        rst_n = 1'b0;
        idle(1);
        chk("R1 reset mid-run", active, 1'b0);
        rst_n = 1'b1;
        idle(1);
        finish_run();
    end

endmodule